// File: doc/BRIEF.md
# Strobed Handshake Port Controller

This block is the strobed-handshake engine that serves one 8-bit data port of a parallel I/O controller. The surrounding controller instantiates it twice. One copy is built for group A and one for group B, and the group is chosen by a parameter. Mode-word decoding, bus steering and the port C set/clear register are done by the surrounding logic. That logic hands this block its direction bit, its interrupt-enable flag and a mode-write pulse.

In input direction, the peripheral pulls a strobe low. While the strobe is low, the block captures the port data into its latch and raises an input-full flag. When the strobe returns high, it can request an interrupt. A host read of the port empties the flag and withdraws the request.

In output direction, a host write asserts an active-low output-full flag towards the peripheral. The peripheral's acknowledge releases that flag. The rising edge of the acknowledge can request an interrupt, and the next host write withdraws it.

The block also reports which port C pins it drives and their levels. It gives the port C status bits that belong to its group, with the enable flag placed at the position of the set/clear bit that controls it.

The strobe and acknowledge pins are asynchronous. Each passes through a two-flop synchroniser and then an edge detector, so a flag reacts on the second clock edge after the edge that first samples the pin change. The host strobes are already synchronous to the clock. A flag reacts to a host strobe on the edge that first samples its change.

Top module: `hsport_ctrl`

## Requirements
- R1: In input direction, the latch loads `port_in` on every clock edge at which the synchronised strobe is low, and holds its value otherwise. In output direction it never loads.
- R2: In input direction, `ibf` goes to 1 on a falling edge of `stb_n` and to 0 on a rising edge of `host_rd_n`. A strobe fall reaches `ibf` on the second clock edge after the edge that first samples it. A host edge reaches `ibf` on the edge that samples it.
- R3: In input direction, `intr` goes to 1 on a rising edge of `stb_n` if `ibf` is 1 and `inte` is 1 at that moment. It goes to 0 on a falling edge of `host_rd_n`.
- R4: In output direction, `obf_n` goes to 0 on a rising edge of `host_wr_n` and to 1 on a falling edge of `ack_n`.
- R5: In output direction, `intr` goes to 1 on a rising edge of `ack_n` if `obf_n` is 1 and `inte` is 1 at that moment. It goes to 0 on a falling edge of `host_wr_n`.
- R6: Group A drives its pins as follows. In input direction, PC5 carries `ibf` and PC3 carries `intr`. In output direction, PC7 carries `obf_n` and PC3 carries `intr`. The strobe is read from PC4 and the acknowledge from PC6. `pc_drive` marks the driven bits, and every undriven bit of `pc_out` is 0.
- R7: Group B drives PC1 and PC0 only. PC1 carries `ibf` in input direction and `obf_n` in output direction, and PC0 carries `intr`. Both handshakes use PC2. The flags of group B behave exactly like those of group A.
- R8: `pc_stat` holds the group's status bits and is 0 elsewhere. `pc_own` marks those bits. For group A in input direction, bit 5 is `ibf`, bit 4 is `inte` and bit 3 is `intr`. For group A in output direction, bit 7 is `obf_n`, bit 6 is `inte` and bit 3 is `intr`. For group B, bit 2 is `inte`, bit 1 is the full flag and bit 0 is `intr`.
- R9: A reset, or a clock edge with `mode_wr` high, leaves `ibf`=0, `intr`=0, `obf_n`=1 and the latch at 0. This takes priority over every other event.
- R10: In output direction, strobe edges and host reads have no effect. In input direction, host writes and acknowledge edges have no effect.
- R11: When a setting edge and a clearing edge reach the same flag on the same clock edge, the setting edge wins. This covers a strobe fall with the end of a read, a strobe rise with the start of a read, a write end with an acknowledge fall, and an acknowledge rise with the start of a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_wr | input | 1 | One-cycle pulse when a mode word is written; clears all flags |
| dir_in | input | 1 | 1 = input direction, 0 = output direction |
| inte | input | 1 | Interrupt enable flag from the port C set/clear bit |
| host_rd_n | input | 1 | Host read strobe for this port, active low, synchronous |
| host_wr_n | input | 1 | Host write strobe for this port, active low, synchronous |
| stb_n | input | 1 | Peripheral strobe pin, active low, asynchronous |
| ack_n | input | 1 | Peripheral acknowledge pin, active low, asynchronous |
| port_in | input | DATA_W | Port data pins |
| latch_q | output | DATA_W | Input latch contents |
| ibf | output | 1 | Input buffer full |
| obf_n | output | 1 | Output buffer full, active low |
| intr | output | 1 | Interrupt request |
| pc_out | output | 8 | Port C pin levels driven by this group |
| pc_drive | output | 8 | Port C pins driven by this group |
| pc_stat | output | 8 | Port C status bits of this group |
| pc_own | output | 8 | Port C status bits owned by this group |

## Verification
The interesting overlaps come from pairs of edges that reach the same flag on the same clock edge. The first pair is a peripheral strobe or acknowledge edge, which takes two synchroniser stages. The second is a host strobe edge, which takes none. The bench makes them coincide by launching the peripheral edge two half-cycle drive points before the host edge. It then checks that the setting edge wins, in all four pairings listed in R11. A behavioural reference model ages the pin history by three sampled edges and the host levels by one. It is compared on every clock, so any shift of one cycle in either path shows up as a mismatch.

// File: rtl/hs_pkg.sv
// Shared types and pin positions for the strobed handshake port controller.
// Assumes a port C of eight bits; pin positions are fixed by the peripheral wiring.
package hs_pkg;
    localparam int PC_W = 8;

    // Level and edges of one handshake line after detection.
    typedef struct packed {
        logic lvl;
        logic rise;
        logic fall;
    } hs_edge_t;

    function automatic int unsigned full_in_pin(bit grp_a);
        return grp_a ? 5 : 1;
    endfunction

    function automatic int unsigned full_out_pin(bit grp_a);
        return grp_a ? 7 : 1;
    endfunction

    function automatic int unsigned intr_pin(bit grp_a);
        return grp_a ? 3 : 0;
    endfunction

    function automatic int unsigned en_in_pin(bit grp_a);
        return grp_a ? 4 : 2;
    endfunction

    function automatic int unsigned en_out_pin(bit grp_a);
        return grp_a ? 6 : 2;
    endfunction
endpackage

// File: rtl/hs_edge_det.sv
// Optional synchroniser followed by an edge detector for one active-low line.
// STAGES = 0 treats the input as already synchronous. Reset loads the idle level.
module hs_edge_det
    import hs_pkg::*;
#(
    parameter int STAGES = 2,
    parameter bit IDLE   = 1'b1
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     d,
    output hs_edge_t ev
);
    logic lvl;
    logic prev;

    generate
        if (STAGES == 0) begin : g_direct
            assign lvl = d;
        end else begin : g_sync
            logic [STAGES-1:0] sh;
            // Shift the raw pin through the synchroniser chain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sh <= {STAGES{IDLE}};
                end else begin
                    sh[0] <= d;
                    for (int i = 1; i < STAGES; i++) begin
                        sh[i] <= sh[i-1];
                    end
                end
            end
            assign lvl = sh[STAGES-1];
        end
    endgenerate

    // Hold the level of the previous cycle for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= IDLE;
        else        prev <= lvl;
    end

    assign ev.lvl  = lvl;
    assign ev.rise = ~prev & lvl;
    assign ev.fall = prev & ~lvl;
endmodule

// File: rtl/hs_flag_engine.sv
// Flag and latch state of one handshake port.
// Assumes edges arrive as one-cycle pulses; a setting event beats a clearing one.
module hs_flag_engine
    import hs_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wr,
    input  logic              dir_in,
    input  logic              inte,
    input  hs_edge_t          stb,
    input  hs_edge_t          ack,
    input  hs_edge_t          rd,
    input  hs_edge_t          wr,
    input  logic [DATA_W-1:0] port_in,
    output logic [DATA_W-1:0] latch_q,
    output logic              ibf,
    output logic              obf_n,
    output logic              intr
);
    // Capture port data while the strobe is held low.
    always_ff @(posedge clk) begin
        if (!rst_n || mode_wr)       latch_q <= '0;
        else if (dir_in && !stb.lvl) latch_q <= port_in;
    end

    // Input buffer full: strobe fall sets, read end clears.
    always_ff @(posedge clk) begin
        if (!rst_n || mode_wr) ibf <= 1'b0;
        else if (dir_in) begin
            if (stb.fall)     ibf <= 1'b1;
            else if (rd.rise) ibf <= 1'b0;
        end
    end

    // Output buffer full (active low): write end asserts, ack fall releases.
    always_ff @(posedge clk) begin
        if (!rst_n || mode_wr) obf_n <= 1'b1;
        else if (!dir_in) begin
            if (wr.rise)       obf_n <= 1'b0;
            else if (ack.fall) obf_n <= 1'b1;
        end
    end

    // Interrupt request for either direction.
    always_ff @(posedge clk) begin
        if (!rst_n || mode_wr) intr <= 1'b0;
        else if (dir_in) begin
            if (stb.rise && ibf && inte) intr <= 1'b1;
            else if (rd.fall)            intr <= 1'b0;
        end else begin
            if (ack.rise && obf_n && inte) intr <= 1'b1;
            else if (wr.fall)              intr <= 1'b0;
        end
    end

    p_ibf_set_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ibf) |-> $past(dir_in) && $past(stb.fall));
    p_ibf_clear_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ibf) |-> $past(mode_wr) || $past(rd.lvl));
    p_obf_assert_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(obf_n) |-> !$past(dir_in) && $past(wr.lvl));
    p_obf_release_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(obf_n) |-> $past(mode_wr) || !$past(ack.lvl));
    p_intr_needs_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(intr) |-> $past(inte) && ($past(stb.rise) || $past(ack.rise)));
    p_mode_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr |=> !ibf && !intr && obf_n && latch_q == '0);
endmodule

// File: rtl/hs_pin_map.sv
// Places the flags of one group onto port C pins and status bits.
// Assumes group A or B is fixed at elaboration time by IS_GRP_A.
module hs_pin_map
    import hs_pkg::*;
#(
    parameter bit IS_GRP_A = 1'b1
) (
    input  logic            dir_in,
    input  logic            inte,
    input  logic            ibf,
    input  logic            obf_n,
    input  logic            intr,
    output logic [PC_W-1:0] pc_out,
    output logic [PC_W-1:0] pc_drive,
    output logic [PC_W-1:0] pc_stat,
    output logic [PC_W-1:0] pc_own
);
    localparam int unsigned FULL_IN  = full_in_pin(IS_GRP_A);
    localparam int unsigned FULL_OUT = full_out_pin(IS_GRP_A);
    localparam int unsigned INTR_P   = intr_pin(IS_GRP_A);
    localparam int unsigned EN_IN    = en_in_pin(IS_GRP_A);
    localparam int unsigned EN_OUT   = en_out_pin(IS_GRP_A);

    logic full_lvl;
    logic [$clog2(PC_W)-1:0] full_pos;
    logic [$clog2(PC_W)-1:0] en_pos;

    // Pick the full-flag level and positions for the current direction.
    always_comb begin
        full_lvl = dir_in ? ibf : obf_n;
        full_pos = dir_in ? FULL_IN[$clog2(PC_W)-1:0] : FULL_OUT[$clog2(PC_W)-1:0];
        en_pos   = dir_in ? EN_IN[$clog2(PC_W)-1:0]   : EN_OUT[$clog2(PC_W)-1:0];
    end

    // Build driven pins and status bits.
    always_comb begin
        pc_out   = '0;
        pc_drive = '0;
        pc_stat  = '0;
        pc_own   = '0;
        pc_out[full_pos]   = full_lvl;
        pc_out[INTR_P]     = intr;
        pc_drive[full_pos] = 1'b1;
        pc_drive[INTR_P]   = 1'b1;
        pc_stat[full_pos]  = full_lvl;
        pc_stat[en_pos]    = inte;
        pc_stat[INTR_P]    = intr;
        pc_own[full_pos]   = 1'b1;
        pc_own[en_pos]     = 1'b1;
        pc_own[INTR_P]     = 1'b1;
    end
endmodule

// File: rtl/hsport_ctrl.sv
// Strobed handshake controller for one 8-bit port (group A or B).
// Assumes host strobes are synchronous to clk; peripheral pins are not.
module hsport_ctrl
    import hs_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter bit IS_GRP_A    = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wr,
    input  logic              dir_in,
    input  logic              inte,
    input  logic              host_rd_n,
    input  logic              host_wr_n,
    input  logic              stb_n,
    input  logic              ack_n,
    input  logic [DATA_W-1:0] port_in,
    output logic [DATA_W-1:0] latch_q,
    output logic              ibf,
    output logic              obf_n,
    output logic              intr,
    output logic [PC_W-1:0]   pc_out,
    output logic [PC_W-1:0]   pc_drive,
    output logic [PC_W-1:0]   pc_stat,
    output logic [PC_W-1:0]   pc_own
);
    hs_edge_t stb_e, ack_e, rd_e, wr_e;

    hs_edge_det #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_stb (
        .clk(clk), .rst_n(rst_n), .d(stb_n), .ev(stb_e));
    hs_edge_det #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_ack (
        .clk(clk), .rst_n(rst_n), .d(ack_n), .ev(ack_e));
    hs_edge_det #(.STAGES(0), .IDLE(1'b1)) u_rd (
        .clk(clk), .rst_n(rst_n), .d(host_rd_n), .ev(rd_e));
    hs_edge_det #(.STAGES(0), .IDLE(1'b1)) u_wr (
        .clk(clk), .rst_n(rst_n), .d(host_wr_n), .ev(wr_e));

    hs_flag_engine #(.DATA_W(DATA_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .dir_in(dir_in), .inte(inte),
        .stb(stb_e), .ack(ack_e), .rd(rd_e), .wr(wr_e), .port_in(port_in),
        .latch_q(latch_q), .ibf(ibf), .obf_n(obf_n), .intr(intr));

    hs_pin_map #(.IS_GRP_A(IS_GRP_A)) u_map (
        .dir_in(dir_in), .inte(inte), .ibf(ibf), .obf_n(obf_n), .intr(intr),
        .pc_out(pc_out), .pc_drive(pc_drive), .pc_stat(pc_stat), .pc_own(pc_own));

    p_drive_within_own_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_drive & ~pc_own) == '0);
    p_undriven_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_out & ~pc_drive) == '0);
endmodule

// File: tb/sim_hsport_ctrl.sv
// Bench: behavioural reference model compared on every clock; group A in u0,
// group B in u1 sharing the same handshake activity.
module sim_hsport_ctrl;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n = 1'b0, mode_wr = 1'b0, dir_in = 1'b1, inte = 1'b0;
    logic rd_n = 1'b1, wr_n = 1'b1, stb_n = 1'b1, ack_n = 1'b1;
    logic [7:0] port_in = 8'h00;
    logic hs_b;
    assign hs_b = dir_in ? stb_n : ack_n;

    logic [7:0] a_latch, a_out, a_drv, a_stat, a_own;
    logic a_ibf, a_obfn, a_intr;
    logic [7:0] b_latch, b_out, b_drv, b_stat, b_own;
    logic b_ibf, b_obfn, b_intr;

    hsport_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .dir_in(dir_in), .inte(inte),
        .host_rd_n(rd_n), .host_wr_n(wr_n), .stb_n(stb_n), .ack_n(ack_n),
        .port_in(port_in), .latch_q(a_latch), .ibf(a_ibf), .obf_n(a_obfn),
        .intr(a_intr), .pc_out(a_out), .pc_drive(a_drv), .pc_stat(a_stat), .pc_own(a_own));

    hsport_ctrl #(.IS_GRP_A(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .dir_in(dir_in), .inte(inte),
        .host_rd_n(rd_n), .host_wr_n(wr_n), .stb_n(hs_b), .ack_n(hs_b),
        .port_in(port_in), .latch_q(b_latch), .ibf(b_ibf), .obf_n(b_obfn),
        .intr(b_intr), .pc_out(b_out), .pc_drive(b_drv), .pc_stat(b_stat), .pc_own(b_own));

    int n_chk = 0, n_fail = 0;
    bit started = 0, done = 0;

    // Reference model state.
    bit sq[$], aq[$];
    bit rd_prev, wr_prev;
    bit m_ibf, m_obfn, m_intr;
    logic [7:0] m_latch;

    always @(posedge clk) begin
        bit sfall, srise, afall, arise, rdr, rdf, wrr, wrf, old_ibf, old_obfn;
        if (!rst_n) begin
            sq = '{1, 1, 1}; aq = '{1, 1, 1};
            rd_prev = 1; wr_prev = 1;
            m_ibf = 0; m_obfn = 1; m_intr = 0; m_latch = 8'h00;
        end else begin
            sfall = sq[2] && !sq[1]; srise = !sq[2] && sq[1];
            afall = aq[2] && !aq[1]; arise = !aq[2] && aq[1];
            rdr = !rd_prev && rd_n;  rdf = rd_prev && !rd_n;
            wrr = !wr_prev && wr_n;  wrf = wr_prev && !wr_n;
            old_ibf = m_ibf; old_obfn = m_obfn;
            if (mode_wr) begin
                m_ibf = 0; m_obfn = 1; m_intr = 0; m_latch = 8'h00;
            end else if (dir_in) begin
                if (!sq[1]) m_latch = port_in;
                if (sfall) m_ibf = 1; else if (rdr) m_ibf = 0;
                if (srise && old_ibf && inte) m_intr = 1; else if (rdf) m_intr = 0;
            end else begin
                if (wrr) m_obfn = 0; else if (afall) m_obfn = 1;
                if (arise && old_obfn && inte) m_intr = 1; else if (wrf) m_intr = 0;
            end
            rd_prev = rd_n; wr_prev = wr_n;
        end
        sq.push_front(stb_n); void'(sq.pop_back());
        aq.push_front(ack_n); void'(aq.pop_back());
    end

    task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Expected port C map from the requirement tables R6, R7, R8.
    task automatic expmap(bit ga, output logic [7:0] o, output logic [7:0] d,
                          output logic [7:0] s, output logic [7:0] w);
        bit full;
        full = dir_in ? m_ibf : m_obfn;
        o = 0; d = 0; s = 0; w = 0;
        if (ga) begin
            if (dir_in) begin
                o[5] = full; d[5] = 1; s[5] = full; s[4] = inte; w[5] = 1; w[4] = 1;
            end else begin
                o[7] = full; d[7] = 1; s[7] = full; s[6] = inte; w[7] = 1; w[6] = 1;
            end
            o[3] = m_intr; d[3] = 1; s[3] = m_intr; w[3] = 1;
        end else begin
            o[1] = full; o[0] = m_intr; d = 8'h03;
            s[2] = inte; s[1] = full; s[0] = m_intr; w = 8'h07;
        end
    endtask

    task automatic flags(string tag);
        chk(tag, "ibf", {7'd0, a_ibf}, {7'd0, m_ibf});
        chk(tag, "obf_n", {7'd0, a_obfn}, {7'd0, m_obfn});
        chk(tag, "intr", {7'd0, a_intr}, {7'd0, m_intr});
        chk(tag, "latch", a_latch, m_latch);
    endtask

    // Per-clock comparison, sampled mid-cycle after the model updated.
    always @(posedge clk) begin
        logic [7:0] o, d, s, w;
        #5;
        if (started && !done) begin
            chk("R1", "latch", a_latch, m_latch);
            chk("R2", "ibf", {7'd0, a_ibf}, {7'd0, m_ibf});
            chk(dir_in ? "R3" : "R5", "intr", {7'd0, a_intr}, {7'd0, m_intr});
            chk("R4", "obf_n", {7'd0, a_obfn}, {7'd0, m_obfn});
            expmap(1'b1, o, d, s, w);
            chk("R6", "A pc_out", a_out, o);
            chk("R6", "A pc_drive", a_drv, d);
            chk("R8", "A pc_stat", a_stat, s);
            chk("R8", "A pc_own", a_own, w);
            expmap(1'b0, o, d, s, w);
            chk("R7", "B pc_out", b_out, o);
            chk("R7", "B pc_drive", b_drv, d);
            chk("R8", "B pc_stat", b_stat, s);
            chk("R8", "B pc_own", b_own, w);
            chk("R7", "B flags", {5'd0, b_ibf, b_obfn, b_intr}, {5'd0, m_ibf, m_obfn, m_intr});
            chk("R7", "B latch", b_latch, m_latch);
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic mode(bit dir, bit en);
        mode_wr = 1; dir_in = dir; inte = en; tick(1);
        mode_wr = 0; tick(1);
        flags("R9");
    endtask

    task automatic strobe(logic [7:0] data, int len);
        port_in = data; stb_n = 0; tick(len); stb_n = 1; tick(5);
    endtask

    task automatic hread(int len);
        rd_n = 0; tick(len); rd_n = 1; tick(2);
    endtask

    task automatic hwrite(int len);
        wr_n = 0; tick(len); wr_n = 1; tick(2);
    endtask

    task automatic ackp(int len);
        ack_n = 0; tick(len); ack_n = 1; tick(5);
    endtask

    initial begin
        tick(1); started = 1;
        tick(2); flags("R9");
        rst_n = 1; tick(2);
        // Input direction.
        mode(1, 1);
        strobe(8'hA5, 4); flags("R3");
        hread(2); flags("R2");
        inte = 0; strobe(8'h3C, 3); flags("R3");
        hread(2);
        inte = 1; strobe(8'h11, 3);
        rd_n = 0; tick(3);
        // R11: strobe fall meets read end.
        port_in = 8'h22; stb_n = 0; tick(2); rd_n = 1; tick(1); flags("R11");
        stb_n = 1; tick(5);
        // R11: strobe rise meets read start.
        stb_n = 0; tick(3); stb_n = 1; tick(2); rd_n = 0; tick(1); flags("R11");
        tick(3); rd_n = 1; tick(2);
        // R10: output-side events ignored in input direction.
        hwrite(2); ackp(3); flags("R10");
        // Output direction.
        mode(0, 1);
        strobe(8'h77, 3); hread(2); flags("R10");
        hwrite(2); flags("R4");
        ackp(3); flags("R5");
        hwrite(2); flags("R5");
        inte = 0; ackp(3); flags("R5");
        // R11: write end meets acknowledge fall.
        wr_n = 0; tick(2); ack_n = 0; tick(2); wr_n = 1; tick(1); flags("R11");
        tick(2); ack_n = 1; tick(5);
        // R11: acknowledge rise meets write start.
        inte = 1; ack_n = 0; tick(4); ack_n = 1; tick(2); wr_n = 0; tick(1); flags("R11");
        tick(3); wr_n = 1; tick(2);
        ackp(3);
        // R9: mode write clears pending flags.
        mode(1, 0);
        strobe(8'h5A, 3);
        mode(0, 0);
        tick(3);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule